// File: doc/BRIEF.md
# DRAM Read-Calibration Command Sequencer

This block sits on the controller side of a DDR3-style memory interface and runs a system-level read timing calibration. After a single-cycle start request it drives the command bus through a fixed order of steps. It closes all banks with a precharge-all command. It then switches the memory into its fixed-pattern read mode with a mode-register write to MR3. In that mode it issues calibration reads one after another. Each returned burst is compared against the known alternating pattern. While a burst fails, the block steps a capture delay tap by one and reads again. It stops on the first passing tap or when the tap range is used up. It then switches the memory back to normal mode, waits the mode-update delay and reports the result.

Every timing interval is a module parameter counted in clock cycles: precharge recovery, mode-register command delay, mode-update delay, pattern-read-to-mode-write recovery, additive latency and CAS latency. One shared down-counter enforces all of them. The physical layer, the delay lines and the memory itself lie outside the block. The block only drives the delay tap value and samples the read data handed to it together with a valid strobe.

Top module: `rdcal_seq`

## Requirements
- R1: The command field uses the codes 000 NOP, 001 precharge, 010 mode-register write, 011 read and 100 write. After reset the block shows cmd_o = NOP, busy = 0, done = 0, fail = 0 and dly_tap = 0.
- R2: A start pulse in idle first issues a precharge with addr_o[10] = 1 (all banks). At least TRP cycles later it issues a mode-register write with ba_o = 011 (MR3), addr_o[2] = 1 and addr_o[1:0] = 00.
- R3: The first calibration read comes no earlier than max(TMRD, TMOD) cycles after the enabling mode-register write.
- R4: Every calibration read has ba_o = 000, addr_o[12] = 1 and addr_o[2:0] = 000. Consecutive reads are at least AL+CL+8 cycles apart, so bursts never overlap.
- R5: A burst passes only if exactly 8 valid beats arrive before the evaluation point and beat k carries every data bit equal to k mod 2 (0,1,0,1,0,1,0,1). A corrupted beat or a missing beat makes it fail.
- R6: dly_tap is cleared to 0 at each start and rises by exactly 1 after each failing burst. The first passing tap is held on dly_tap after completion.
- R7: If the burst read at the largest tap (all ones) fails, the run ends with fail = 1, done = 1 and dly_tap held at its maximum. A run with a pass ends with fail = 0.
- R8: The exit mode-register write (ba_o = 011, addr_o[2] = 0) comes no earlier than TMPRR cycles after the last read. done rises no earlier than max(TMRD, TMOD) cycles after that write.
- R9: The block never issues a write command, and no two commands ever appear on adjacent cycles.
- R10: A start pulse while busy = 1 is ignored: the run's command sequence and result are unchanged.
- R11: done and fail, while busy = 0, hold until the next start. A new start clears both and raises busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to run a calibration |
| rd_valid | input | 1 | Read data beat valid strobe |
| rd_data | input | DQ_W | Captured read data beat |
| cmd_o | output | 3 | Command code to the memory |
| ba_o | output | 3 | Bank address / mode-register select |
| addr_o | output | 14 | Row/column address bus |
| dly_tap | output | TAP_W | Capture delay tap for the read path |
| busy | output | 1 | A calibration run is in progress |
| done | output | 1 | Last run finished |
| fail | output | 1 | Last run found no passing tap |

## Verification
A memory model in the bench answers each read according to the tap in use. It is tried with a pass window starting at tap 3, with a window covering every tap (first read passes), and with no window at all, which separates the stepping, immediate-pass and saturation-to-fail outcomes. Two further patterns share a window that is open from tap 0. In one, the tap-0 burst has a flipped data bit. In the other, the tap-0 burst drops one beat. Both must still land on tap 1, which shows that content and beat count are each judged. A start pulse injected mid-run confirms that it leaves the command stream untouched. The command stream is scored item by item, and all timing gaps are measured against the parameters.

// File: rtl/rdcal_pkg.sv
package rdcal_pkg;

    localparam int BA_W      = 3;
    localparam int ADDR_W    = 14;
    localparam int BURST_LEN = 8;

    localparam int A_ALLBANK = 10;
    localparam int A_PATMODE = 2;
    localparam int A_BL8     = 12;
    localparam logic [BA_W-1:0] BA_MR3 = 3'b011;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_PRE = 3'd1,
        CMD_MRS = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4
    } dram_cmd_e;

    typedef enum logic [3:0] {
        S_IDLE, S_PRE, S_W_RP, S_PAT_ON, S_W_ON, S_READ, S_W_RD,
        S_EVAL, S_W_MPRR, S_PAT_OFF, S_W_OFF, S_FIN
    } seq_state_e;

    typedef struct packed {
        dram_cmd_e             cmd;
        logic [BA_W-1:0]       ba;
        logic [ADDR_W-1:0]     addr;
    } cmd_bus_t;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // expected level of every data bit in beat idx of the pattern burst
    function automatic logic beat_level(int unsigned idx);
        return idx[0];
    endfunction

    // command bus contents issued in a given sequencer state
    function automatic cmd_bus_t cmd_for_state(seq_state_e s);
        cmd_bus_t c;
        c = '{cmd: CMD_NOP, ba: '0, addr: '0};
        case (s)
            S_PRE: begin
                c.cmd = CMD_PRE;
                c.addr[A_ALLBANK] = 1'b1;
            end
            S_PAT_ON: begin
                c.cmd = CMD_MRS;
                c.ba  = BA_MR3;
                c.addr[A_PATMODE] = 1'b1;
            end
            S_READ: begin
                c.cmd = CMD_RD;
                c.addr[A_BL8] = 1'b1;
            end
            S_PAT_OFF: begin
                c.cmd = CMD_MRS;
                c.ba  = BA_MR3;
            end
            default: c = '{cmd: CMD_NOP, ba: '0, addr: '0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rdcal_timer.sv
module rdcal_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/rdcal_burst_chk.sv
module rdcal_burst_chk
    import rdcal_pkg::*;
#(
    parameter int DQ_W  = 16,
    parameter int BEATS = BURST_LEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            valid,
    input  logic [DQ_W-1:0] data,
    output logic            pass
);
    localparam int CNT_W = $clog2(BEATS + 1);

    logic [CNT_W-1:0] cnt;
    logic             bad;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
            bad <= 1'b0;
        end else if (valid) begin
            if (cnt == CNT_W'(BEATS)) begin
                bad <= 1'b1;
            end else begin
                if (data != {DQ_W{beat_level(32'(cnt))}})
                    bad <= 1'b1;
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign pass = (cnt == CNT_W'(BEATS)) && !bad;
endmodule

// File: rtl/rdcal_tap.sv
module rdcal_tap #(
    parameter int TAP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [TAP_W-1:0] tap,
    output logic             at_max
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            tap <= '0;
        else if (step && !at_max)
            tap <= tap + 1'b1;
    end

    assign at_max = &tap;
endmodule

// File: rtl/rdcal_seq.sv
module rdcal_seq
    import rdcal_pkg::*;
#(
    parameter int TRP   = 6,
    parameter int TMRD  = 4,
    parameter int TMOD  = 12,
    parameter int TMPRR = 2,
    parameter int AL    = 0,
    parameter int CL    = 6,
    parameter int TAP_W = 4,
    parameter int DQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rd_valid,
    input  logic [DQ_W-1:0]   rd_data,
    output logic [2:0]        cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [TAP_W-1:0]  dly_tap,
    output logic              busy,
    output logic              done,
    output logic              fail
);
    localparam int RL      = AL + CL;
    localparam int T_RP    = max2(TRP, 2);
    localparam int T_MODE  = max2(max2(TMRD, TMOD), 2);
    localparam int T_MPRR  = max2(TMPRR, 2);
    localparam int T_RDWIN = RL + BURST_LEN + 1;
    localparam int T_MAX   = max2(max2(T_RP, T_MODE), max2(T_MPRR, T_RDWIN));
    localparam int TMR_W   = $clog2(T_MAX + 1);

    seq_state_e       st, nxt;
    logic             tmr_ld, tmr_exp;
    logic [TMR_W-1:0] tmr_val;
    logic             tap_clr, tap_step, tap_max;
    logic             chk_clr, chk_pass;
    logic             done_q, fail_q;
    cmd_bus_t         bus;

    rdcal_timer #(.W(TMR_W)) timer_i (
        .clk(clk), .rst(rst), .load(tmr_ld), .load_val(tmr_val), .expired(tmr_exp)
    );

    rdcal_burst_chk #(.DQ_W(DQ_W), .BEATS(BURST_LEN)) burst_i (
        .clk(clk), .rst(rst), .clear(chk_clr), .valid(rd_valid),
        .data(rd_data), .pass(chk_pass)
    );

    rdcal_tap #(.TAP_W(TAP_W)) tap_i (
        .clk(clk), .rst(rst), .clear(tap_clr), .step(tap_step),
        .tap(dly_tap), .at_max(tap_max)
    );

    always_comb begin
        nxt      = st;
        tmr_ld   = 1'b0;
        tmr_val  = '0;
        tap_clr  = 1'b0;
        tap_step = 1'b0;
        chk_clr  = 1'b0;
        case (st)
            S_IDLE: if (start) begin
                nxt     = S_PRE;
                tap_clr = 1'b1;
            end
            S_PRE: begin
                tmr_ld  = 1'b1;
                tmr_val = TMR_W'(T_RP - 2);
                nxt     = S_W_RP;
            end
            S_W_RP:   if (tmr_exp) nxt = S_PAT_ON;
            S_PAT_ON: begin
                tmr_ld  = 1'b1;
                tmr_val = TMR_W'(T_MODE - 2);
                nxt     = S_W_ON;
            end
            S_W_ON:   if (tmr_exp) nxt = S_READ;
            S_READ: begin
                chk_clr = 1'b1;
                tmr_ld  = 1'b1;
                tmr_val = TMR_W'(T_RDWIN - 2);
                nxt     = S_W_RD;
            end
            S_W_RD:   if (tmr_exp) nxt = S_EVAL;
            S_EVAL: begin
                if (chk_pass || tap_max) begin
                    tmr_ld  = 1'b1;
                    tmr_val = TMR_W'(T_MPRR - 2);
                    nxt     = S_W_MPRR;
                end else begin
                    tap_step = 1'b1;
                    nxt      = S_READ;
                end
            end
            S_W_MPRR: if (tmr_exp) nxt = S_PAT_OFF;
            S_PAT_OFF: begin
                tmr_ld  = 1'b1;
                tmr_val = TMR_W'(T_MODE - 2);
                nxt     = S_W_OFF;
            end
            S_W_OFF:  if (tmr_exp) nxt = S_FIN;
            S_FIN:    nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= S_IDLE;
        else
            st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else if (st == S_IDLE && start) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else if (st == S_FIN) begin
            done_q <= 1'b1;
            fail_q <= !chk_pass;
        end
    end

    assign bus    = cmd_for_state(st);
    assign cmd_o  = bus.cmd;
    assign ba_o   = bus.ba;
    assign addr_o = bus.addr;
    assign busy   = (st != S_IDLE);
    assign done   = done_q;
    assign fail   = fail_q;
endmodule

// File: rtl/rdcal_seq_chk.sv
module rdcal_seq_chk
    import rdcal_pkg::*;
#(
    parameter int TAP_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cmd_o,
    input logic [BA_W-1:0]   ba_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [TAP_W-1:0]  dly_tap,
    input logic              busy,
    input logic              done,
    input logic              fail
);
    // R9
    no_write_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_o != 3'(CMD_WR));

    // R9
    cmd_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_o != 3'(CMD_NOP) |=> cmd_o == 3'(CMD_NOP));

    // R4
    rd_addr_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_o == 3'(CMD_RD) |-> (addr_o[A_BL8] && addr_o[2:0] == 3'b000 && ba_o == '0));

    // R2
    mrs_target_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_o == 3'(CMD_MRS) |-> (ba_o == BA_MR3 && addr_o[1:0] == 2'b00));

    // R6
    tap_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(dly_tap)) |-> dly_tap == TAP_W'($past(dly_tap) + 1'b1));

    // R11
    fail_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        fail |-> done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind rdcal_seq rdcal_seq_chk #(.TAP_W(TAP_W)) chk_i (
    .clk(clk), .rst(rst), .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o),
    .dly_tap(dly_tap), .busy(busy), .done(done), .fail(fail)
);

// File: tb/rdcal_seq_tb_top.sv
module rdcal_seq_tb_top;
    import rdcal_pkg::*;

    localparam int TRP = 6, TMRD = 4, TMOD = 12, TMPRR = 2, AL = 0, CL = 6;
    localparam int TAP_W = 4, DQ_W = 16;
    localparam int RL = AL + CL;
    localparam int T_MODX = (TMRD > TMOD) ? TMRD : TMOD;
    localparam int NTAPS = 1 << TAP_W;

    logic clk = 0;
    logic rst = 1;
    logic start = 0;
    logic rd_valid = 0;
    logic [DQ_W-1:0] rd_data = '0;
    logic [2:0] cmd_o;
    logic [BA_W-1:0] ba_o;
    logic [ADDR_W-1:0] addr_o;
    logic [TAP_W-1:0] dly_tap;
    logic busy, done, fail;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    // memory model settings
    int good_lo = 0, good_hi = -1;
    bit drop0 = 0, flip0 = 0;
    int rd_at = -1000;
    bit rd_ok = 0, rd_drop = 0;

    // command tracking
    int pre_cyc = 0, on_cyc = 0, last_rd = -1000, off_cyc = 0, prev_cmd = -100;
    bit first_rd = 0;

    cmd_bus_t exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rdcal_seq #(.TRP(TRP), .TMRD(TMRD), .TMOD(TMOD), .TMPRR(TMPRR), .AL(AL), .CL(CL),
                .TAP_W(TAP_W), .DQ_W(DQ_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .rd_valid(rd_valid), .rd_data(rd_data),
        .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o), .dly_tap(dly_tap),
        .busy(busy), .done(done), .fail(fail)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit tap_passes(int t);
        if (t < good_lo || t > good_hi) return 0;
        if (t == 0 && (drop0 || flip0)) return 0;
        return 1;
    endfunction

    // memory model and scoreboard monitor
    always @(negedge clk) begin : mon
        int k;
        cmd_bus_t got, want;
        if (rst) begin
            rd_valid <= 0;
            rd_data  <= '0;
        end else begin
            k = cyc - rd_at;
            if (k >= RL && k < RL + BURST_LEN && !(rd_drop && k == RL + 4)) begin
                rd_valid <= 1;
                rd_data  <= {DQ_W{1'(k - RL)}} ^ ((!rd_ok && k == RL + 5) ? 16'h0008 : 16'h0000);
            end else begin
                rd_valid <= 0;
                rd_data  <= '0;
            end
            if (cmd_o != 3'(CMD_NOP)) begin
                got = '{cmd: dram_cmd_e'(cmd_o), ba: ba_o, addr: addr_o};
                chk(cmd_o != 3'(CMD_WR), "R9", "write command issued", int'(cmd_o), 0);
                chk(cyc - prev_cmd > 1, "R9", "adjacent commands gap", cyc - prev_cmd, 2);
                prev_cmd = cyc;
                if (exp_q.size() == 0) begin
                    chk(0, "R10", "unexpected command", int'(got), 0);
                end else begin
                    want = exp_q.pop_front();
                    chk(got == want, (want.cmd == CMD_RD) ? "R4" : (want.addr[A_PATMODE] ? "R2" : "R8"),
                        "command bus", int'(got), int'(want));
                end
                if (cmd_o == 3'(CMD_PRE)) pre_cyc = cyc;
                if (cmd_o == 3'(CMD_MRS) && addr_o[A_PATMODE]) begin
                    chk(cyc - pre_cyc >= TRP, "R2", "precharge to MR3 gap", cyc - pre_cyc, TRP);
                    on_cyc = cyc;
                    first_rd = 1;
                end
                if (cmd_o == 3'(CMD_MRS) && !addr_o[A_PATMODE]) begin
                    chk(cyc - last_rd >= TMPRR, "R8", "last read to exit gap", cyc - last_rd, TMPRR);
                    off_cyc = cyc;
                end
                if (cmd_o == 3'(CMD_RD)) begin
                    if (first_rd)
                        chk(cyc - on_cyc >= T_MODX, "R3", "enable to first read gap", cyc - on_cyc, T_MODX);
                    else
                        chk(cyc - last_rd >= RL + BURST_LEN, "R4", "read to read gap", cyc - last_rd, RL + BURST_LEN);
                    first_rd = 0;
                    last_rd = cyc;
                    rd_at = cyc;
                    rd_ok = tap_passes(int'(dly_tap)) || !(flip0 && dly_tap == 0) && (int'(dly_tap) >= good_lo && int'(dly_tap) <= good_hi);
                    rd_drop = drop0 && dly_tap == 0;
                end
            end
        end
    end

    task automatic run_case(input int lo, input int hi, input bit drp, input bit flp,
                            input bit poke, input string req);
        int exp_tap, nreads, lim;
        bit exp_fail;
        good_lo = lo; good_hi = hi; drop0 = drp; flip0 = flp;
        exp_fail = 1; exp_tap = NTAPS - 1; nreads = NTAPS;
        for (int t = 0; t < NTAPS; t++) begin
            if (tap_passes(t)) begin
                exp_fail = 0; exp_tap = t; nreads = t + 1;
                break;
            end
        end
        exp_q.push_back('{cmd: CMD_PRE, ba: 3'b000, addr: 14'(1 << A_ALLBANK)});
        exp_q.push_back('{cmd: CMD_MRS, ba: 3'b011, addr: 14'(1 << A_PATMODE)});
        for (int i = 0; i < nreads; i++)
            exp_q.push_back('{cmd: CMD_RD, ba: 3'b000, addr: 14'(1 << A_BL8)});
        exp_q.push_back('{cmd: CMD_MRS, ba: 3'b011, addr: 14'd0});

        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        chk(busy == 1, "R11", "busy after start", int'(busy), 1);
        chk(done == 0 && fail == 0, "R11", "done/fail cleared by start", int'({done, fail}), 0);
        if (poke) begin
            repeat (30) @(negedge clk);
            start = 1;
            @(negedge clk) start = 0;
        end
        lim = cyc + 5000;
        while (!done && cyc < lim) @(negedge clk);
        chk(done == 1, req, "done raised", int'(done), 1);
        chk(cyc - off_cyc >= T_MODX, "R8", "exit write to done gap", cyc - off_cyc, T_MODX);
        chk(fail == exp_fail, exp_fail ? "R7" : req, "fail flag", int'(fail), int'(exp_fail));
        chk(int'(dly_tap) == exp_tap, exp_fail ? "R7" : "R6", "final tap", int'(dly_tap), exp_tap);
        chk(exp_q.size() == 0, "R4", "commands left unissued", exp_q.size(), 0);
        exp_q.delete();
        repeat (20) @(negedge clk);
        chk(done == 1 && fail == exp_fail && busy == 0, "R11", "result held in idle",
            int'({busy, done, fail}), int'({1'b0, 1'b1, exp_fail}));
        chk(int'(dly_tap) == exp_tap && cmd_o == 3'(CMD_NOP), "R6", "tap held in idle",
            int'(dly_tap), exp_tap);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(cmd_o == 3'(CMD_NOP) && busy == 0 && done == 0 && fail == 0 && dly_tap == 0,
            "R1", "reset state", int'({cmd_o, busy, done, fail, dly_tap}), 0);
        // R6 stepping to tap 3, with start poked mid-run (R10)
        run_case(3, 5, 0, 0, 1, "R10");
        // R6 immediate pass at tap 0
        run_case(0, NTAPS - 1, 0, 0, 0, "R6");
        // R7 no passing tap at all
        run_case(99, 99, 0, 0, 0, "R7");
        // R5 dropped beat at tap 0
        run_case(0, NTAPS - 1, 1, 0, 0, "R5");
        // R5 corrupted beat at tap 0
        run_case(0, NTAPS - 1, 0, 1, 0, "R5");
        // R6 single-tap window deep in the range
        run_case(7, 7, 0, 0, 0, "R6");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule